// File: doc/BRIEF.md
# Microinstruction Field Decoder and Register-Transfer Datapath

This block turns the three microoperation fields of a microinstruction into register transfers on a small accumulator datapath. The datapath has a 16-bit accumulator (AC), a 16-bit data register (DR), an 11-bit address register (AR) and an 11-bit program counter (PC). It also has an ALU that combines AC with DR and writes its result back into AC. Each 3-bit field goes through its own one-hot decoder. Selected decoder lines are ORed to form register loads and multiplexer selects. As a result, one microinstruction can start up to three microoperations in the same clock cycle.

The field bits come from the sequencer's pipeline register. They are the top nine bits of the 20-bit microinstruction word. The condition, branch and address fields below them belong to the sequencer and are not inputs here. The block drives the main-memory address from AR, write data from DR and a write strobe. Memory read data can load only into DR. Three status bits go back to the sequencer for condition tests: the DR indirect bit, the AC sign and AC-is-zero.

Top module: `uop_datapath`

## Requirements
- R1: While rst_ni is low (asynchronous, active low), AC, DR, AR and PC are 0. So mem_addr_o=0, mem_wdata_o=0, zero_o=1, sign_o=0 and ind_o=0.
- R2: ops_i[8:6] is field F1, ops_i[5:3] is F2 and ops_i[2:0] is F3. A field value of 000 changes no register, and ops_i=0 leaves every output unchanged.
- R3: F1 codes, applied on the rising edge: 001 AC<=AC+DR, 010 AC<=0, 011 AC<=AC+1, 100 AC<=DR. Arithmetic wraps modulo 2^16.
- R4: F2 codes: 001 AC<=AC-DR, 010 AC<=AC|DR, 011 AC<=AC&DR, 100 DR<=mem_rdata_i, 101 DR<=AC, 110 DR<=DR+1, 111 DR[10:0]<=PC.
- R5: F3 codes: 001 AC<=AC^DR, 010 AC<=~AC, 011 AC<=AC<<1 (0 shifted in), 100 AC<=AC>>1 (logical, 0 shifted in), 101 PC<=PC+1, 110 PC<=AR, 111 no operation.
- R6: AR loads only on F1 101 (AR<=DR[10:0]) or F1 110 (AR<=PC). mem_addr_o always shows AR. PC loads only from AR (F3 110) or by increment (F3 101).
- R7: mem_we_o is high, combinationally and in the same cycle, exactly when F1=111. The write data is DR (mem_wdata_o) and the address is AR.
- R8: F2 100 loads mem_rdata_i into DR on the rising edge. Memory data reaches no other register directly.
- R9: All fields act on the same rising edge, and each uses register values from before that edge. For example, F1 101 together with F2 110 loads AR from the old DR while DR increments.
- R10: When more than one field writes AC, F1 wins over F2 and F2 wins over F3. Fields 010 001 000 therefore leave AC=0.
- R11: ind_o=DR[15], sign_o=AC[15] and zero_o=(AC==0). All three follow the registers directly.
- R12: F2 111 replaces only DR[10:0] with PC and keeps DR[15:11].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ops_i | input | 9 | Microoperation fields {F1,F2,F3} from the pipeline register |
| mem_rdata_i | input | 16 | Main-memory read data |
| mem_addr_o | output | 11 | Main-memory address (AR) |
| mem_wdata_o | output | 16 | Main-memory write data (DR) |
| mem_we_o | output | 1 | Main-memory write strobe |
| ind_o | output | 1 | DR[15], indirect bit of the instruction word |
| sign_o | output | 1 | AC[15] |
| zero_o | output | 1 | AC equals zero |

## Verification
The bench applies all 512 field combinations, each from a freshly loaded pseudo-random register state. It reads AC and PC back through DR and AR afterwards, so a wrongly routed decoder line or a wrong AC priority shows up as a corrupted value in the next readback. Directed cases cover four corner cases, listed with the fault each one catches:
- The clear-plus-subtract pair catches a design that lets the subtract win and leaves AC=-DR instead of 0.
- AR load combined with a DR increment catches a design that forwards the new DR value into AR.
- The partial DR load from PC catches a design that zeroes DR[15:11].
- The logical right shift catches a design that copies the sign bit.

Checks on the write strobe taken before the clock edge catch a strobe that was registered and so arrives one cycle late.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int unsigned FLD_W = 3;
  localparam int unsigned N_FLD = 3;
  localparam int unsigned OPS_W = FLD_W * N_FLD;
  localparam int unsigned N_CODE = 1 << FLD_W;

  // field index within ops_i, most significant first
  localparam int unsigned IDX_F1 = 0;
  localparam int unsigned IDX_F2 = 1;
  localparam int unsigned IDX_F3 = 2;

  typedef enum logic [FLD_W-1:0] {
    F1_NOP = 3'd0, F1_ADD = 3'd1, F1_CLRAC = 3'd2, F1_INCAC = 3'd3,
    F1_DR2AC = 3'd4, F1_DR2AR = 3'd5, F1_PC2AR = 3'd6, F1_WRITE = 3'd7
  } f1_code_e;

  typedef enum logic [FLD_W-1:0] {
    F2_NOP = 3'd0, F2_SUB = 3'd1, F2_OR = 3'd2, F2_AND = 3'd3,
    F2_READ = 3'd4, F2_AC2DR = 3'd5, F2_INCDR = 3'd6, F2_PC2DR = 3'd7
  } f2_code_e;

  typedef enum logic [FLD_W-1:0] {
    F3_NOP = 3'd0, F3_XOR = 3'd1, F3_COM = 3'd2, F3_SHL = 3'd3,
    F3_SHR = 3'd4, F3_INCPC = 3'd5, F3_AR2PC = 3'd6, F3_RSVD = 3'd7
  } f3_code_e;

  // DR input source select
  typedef enum logic [1:0] {
    DR_SRC_MEM = 2'd0, DR_SRC_AC = 2'd1, DR_SRC_INC = 2'd2, DR_SRC_PC = 2'd3
  } dr_src_e;
endpackage

// File: rtl/uop_field_dec.sv
module uop_field_dec #(
  parameter int unsigned W = 3,
  localparam int unsigned N = 1 << W
) (
  input  logic [W-1:0] code_i,
  output logic [N-1:0] hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign hot_o[i] = (code_i == W'(i));
  end
endmodule

// File: rtl/uop_ac_path.sv
module uop_ac_path
  import uop_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CODE-1:0] f1_hot_i,
  input  logic [N_CODE-1:0] f2_hot_i,
  input  logic [N_CODE-1:0] f3_hot_i,
  input  logic [DATA_W-1:0] dr_i,
  output logic [DATA_W-1:0] ac_o,
  output logic              ac_zero_o
);
  logic [DATA_W-1:0] ac_q, ac_d;
  logic [DATA_W-1:0] f1_val, f2_val, f3_val;
  logic              f1_wr, f2_wr, f3_wr;

  // per-field write requests onto AC
  assign f1_wr = f1_hot_i[F1_ADD] | f1_hot_i[F1_CLRAC] | f1_hot_i[F1_INCAC] | f1_hot_i[F1_DR2AC];
  assign f2_wr = f2_hot_i[F2_SUB] | f2_hot_i[F2_OR] | f2_hot_i[F2_AND];
  assign f3_wr = f3_hot_i[F3_XOR] | f3_hot_i[F3_COM] | f3_hot_i[F3_SHL] | f3_hot_i[F3_SHR];

  // AND-OR selection per field, decoder lines are one-hot
  always_comb begin
    f1_val = ({DATA_W{f1_hot_i[F1_ADD]}}   & (ac_q + dr_i))
           | ({DATA_W{f1_hot_i[F1_INCAC]}} & (ac_q + DATA_W'(1)))
           | ({DATA_W{f1_hot_i[F1_DR2AC]}} & dr_i);
    f2_val = ({DATA_W{f2_hot_i[F2_SUB]}}   & (ac_q - dr_i))
           | ({DATA_W{f2_hot_i[F2_OR]}}    & (ac_q | dr_i))
           | ({DATA_W{f2_hot_i[F2_AND]}}   & (ac_q & dr_i));
    f3_val = ({DATA_W{f3_hot_i[F3_XOR]}}   & (ac_q ^ dr_i))
           | ({DATA_W{f3_hot_i[F3_COM]}}   & ~ac_q)
           | ({DATA_W{f3_hot_i[F3_SHL]}}   & {ac_q[DATA_W-2:0], 1'b0})
           | ({DATA_W{f3_hot_i[F3_SHR]}}   & {1'b0, ac_q[DATA_W-1:1]});
  end

  // F1 over F2 over F3
  always_comb begin
    if (f1_wr)      ac_d = f1_val;
    else if (f2_wr) ac_d = f2_val;
    else if (f3_wr) ac_d = f3_val;
    else            ac_d = ac_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ac_q <= '0;
    else         ac_q <= ac_d;
  end

  assign ac_o      = ac_q;
  assign ac_zero_o = (ac_q == '0);

  logic unused_hot;
  assign unused_hot = ^{f1_hot_i[F1_NOP], f1_hot_i[F1_DR2AR], f1_hot_i[F1_PC2AR], f1_hot_i[F1_WRITE],
                        f2_hot_i[F2_NOP], f2_hot_i[F2_READ], f2_hot_i[F2_AC2DR], f2_hot_i[F2_INCDR],
                        f2_hot_i[F2_PC2DR], f3_hot_i[F3_NOP], f3_hot_i[F3_INCPC], f3_hot_i[F3_AR2PC],
                        f3_hot_i[F3_RSVD]};
endmodule

// File: rtl/uop_addr_regs.sv
module uop_addr_regs
  import uop_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CODE-1:0] f1_hot_i,
  input  logic [N_CODE-1:0] f2_hot_i,
  input  logic [N_CODE-1:0] f3_hot_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] dr_o,
  output logic [ADDR_W-1:0] ar_o
);
  logic [DATA_W-1:0] dr_q, dr_d;
  logic [ADDR_W-1:0] ar_q, ar_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              dr_ld, ar_ld, ar_sel_dr, pc_ld, pc_inc;
  dr_src_e           dr_src;

  // DR: F2 is its only writer
  assign dr_ld = f2_hot_i[F2_READ] | f2_hot_i[F2_AC2DR] | f2_hot_i[F2_INCDR] | f2_hot_i[F2_PC2DR];
  always_comb begin
    dr_src = DR_SRC_MEM;
    if (f2_hot_i[F2_AC2DR]) dr_src = DR_SRC_AC;
    if (f2_hot_i[F2_INCDR]) dr_src = DR_SRC_INC;
    if (f2_hot_i[F2_PC2DR]) dr_src = DR_SRC_PC;
  end
  always_comb begin
    unique case (dr_src)
      DR_SRC_AC:  dr_d = ac_i;
      DR_SRC_INC: dr_d = dr_q + DATA_W'(1);
      DR_SRC_PC:  dr_d = {dr_q[DATA_W-1:ADDR_W], pc_q};
      default:    dr_d = mem_rdata_i;
    endcase
  end

  // AR: two F1 lines ORed into the load, line 5 steers the mux to DR
  assign ar_ld     = f1_hot_i[F1_DR2AR] | f1_hot_i[F1_PC2AR];
  assign ar_sel_dr = f1_hot_i[F1_DR2AR];
  assign ar_d      = ar_sel_dr ? dr_q[ADDR_W-1:0] : pc_q;

  // PC: loads only from AR, or counts
  assign pc_ld  = f3_hot_i[F3_AR2PC];
  assign pc_inc = f3_hot_i[F3_INCPC];
  assign pc_d   = pc_ld ? ar_q : pc_q + ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q <= '0;
      ar_q <= '0;
      pc_q <= '0;
    end else begin
      if (dr_ld)           dr_q <= dr_d;
      if (ar_ld)           ar_q <= ar_d;
      if (pc_ld || pc_inc) pc_q <= pc_d;
    end
  end

  assign dr_o = dr_q;
  assign ar_o = ar_q;

  logic unused_hot;
  assign unused_hot = ^{f1_hot_i[F1_NOP], f1_hot_i[F1_ADD], f1_hot_i[F1_CLRAC], f1_hot_i[F1_INCAC],
                        f1_hot_i[F1_DR2AC], f1_hot_i[F1_WRITE], f2_hot_i[F2_NOP], f2_hot_i[F2_SUB],
                        f2_hot_i[F2_OR], f2_hot_i[F2_AND], f3_hot_i[F3_NOP], f3_hot_i[F3_XOR],
                        f3_hot_i[F3_COM], f3_hot_i[F3_SHL], f3_hot_i[F3_SHR], f3_hot_i[F3_RSVD]};
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OPS_W-1:0]  ops_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              ind_o,
  output logic              sign_o,
  output logic              zero_o
);
  logic [N_CODE-1:0] hot [N_FLD];
  logic [DATA_W-1:0] ac, dr;
  logic [ADDR_W-1:0] ar;
  logic              ac_zero;

  // one decoder per field, F1 in the top bits
  for (genvar f = 0; f < N_FLD; f++) begin : g_dec
    uop_field_dec #(.W(FLD_W)) u_dec (
      .code_i (ops_i[OPS_W-1-f*FLD_W -: FLD_W]),
      .hot_o  (hot[f])
    );
  end

  uop_ac_path #(.DATA_W(DATA_W)) u_ac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .f1_hot_i  (hot[IDX_F1]),
    .f2_hot_i  (hot[IDX_F2]),
    .f3_hot_i  (hot[IDX_F3]),
    .dr_i      (dr),
    .ac_o      (ac),
    .ac_zero_o (ac_zero)
  );

  uop_addr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .f1_hot_i    (hot[IDX_F1]),
    .f2_hot_i    (hot[IDX_F2]),
    .f3_hot_i    (hot[IDX_F3]),
    .ac_i        (ac),
    .mem_rdata_i (mem_rdata_i),
    .dr_o        (dr),
    .ar_o        (ar)
  );

  assign mem_addr_o  = ar;
  assign mem_wdata_o = dr;
  assign mem_we_o    = hot[IDX_F1][F1_WRITE];
  assign ind_o       = dr[DATA_W-1];
  assign sign_o      = ac[DATA_W-1];
  assign zero_o      = ac_zero;
endmodule

// File: rtl/uop_datapath_chk.sv
module uop_datapath_chk
  import uop_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OPS_W-1:0]  ops_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_we_o,
  input logic              sign_o,
  input logic              zero_o
);
  logic [FLD_W-1:0] f1, f2;
  assign f1 = ops_i[8:6];
  assign f2 = ops_i[5:3];

  p_dr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f2 == 3'd0) |=> $stable(mem_wdata_o));

  p_ar_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f1 != 3'd5 && f1 != 3'd6) |=> $stable(mem_addr_o));

  p_dr_to_ar_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f1 == 3'd5) |=> (mem_addr_o == $past(mem_wdata_o[ADDR_W-1:0])));

  p_read_dr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f2 == 3'd4) |=> (mem_wdata_o == $past(mem_rdata_i)));

  p_clear_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f1 == 3'd2) |=> (zero_o && !sign_o));

  p_dr_to_ac_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f1 == 3'd4) |=> (sign_o == $past(mem_wdata_o[DATA_W-1])
                      && zero_o == ($past(mem_wdata_o) == '0)));

  p_we_only_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (f1 == 3'd7));
endmodule

bind uop_datapath uop_datapath_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ops_i       (ops_i),
  .mem_rdata_i (mem_rdata_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_we_o    (mem_we_o),
  .sign_o      (sign_o),
  .zero_o      (zero_o)
);

// File: tb/uop_datapath_tb_top.sv
`timescale 1ns/1ps
module uop_datapath_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  ops_i = '0;
  logic [15:0] mem_rdata_i = '0;
  logic [10:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_we_o, ind_o, sign_o, zero_o;

  always #2.5 clk_i = ~clk_i;

  uop_datapath dut_i (
    .clk_i, .rst_ni, .ops_i, .mem_rdata_i,
    .mem_addr_o, .mem_wdata_o, .mem_we_o, .ind_o, .sign_o, .zero_o
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_ac = '0, m_dr = '0;
  logic [10:0] m_ar = '0, m_pc = '0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed[15:0];
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " DR"}, 32'(mem_wdata_o), 32'(m_dr));
    chk({tag, " AR"}, 32'(mem_addr_o), 32'(m_ar));
    chk("R11 ind_o",  32'(ind_o),  32'(m_dr[15]));
    chk("R11 sign_o", 32'(sign_o), 32'(m_ac[15]));
    chk("R11 zero_o", 32'(zero_o), 32'(m_ac == 16'd0));
  endtask

  task automatic step(input logic [2:0] f1, input logic [2:0] f2, input logic [2:0] f3,
                      input logic [15:0] rd, input string tag);
    logic [15:0] ac_n, dr_n;
    logic [10:0] ar_n, pc_n;
    @(negedge clk_i);
    ops_i = {f1, f2, f3};
    mem_rdata_i = rd;
    #1;
    chk("R7 write strobe", 32'(mem_we_o), 32'(f1 == 3'd7));
    chk("R7 write address", 32'(mem_addr_o), 32'(m_ar));
    ac_n = m_ac; dr_n = m_dr; ar_n = m_ar; pc_n = m_pc;
    case (f3)
      3'd1: ac_n = m_ac ^ m_dr;
      3'd2: ac_n = ~m_ac;
      3'd3: ac_n = m_ac << 1;
      3'd4: ac_n = m_ac >> 1;
      3'd5: pc_n = m_pc + 11'd1;
      3'd6: pc_n = m_ar;
      default: ;
    endcase
    case (f2)
      3'd1: ac_n = m_ac - m_dr;
      3'd2: ac_n = m_ac | m_dr;
      3'd3: ac_n = m_ac & m_dr;
      3'd4: dr_n = rd;
      3'd5: dr_n = m_ac;
      3'd6: dr_n = m_dr + 16'd1;
      3'd7: dr_n = {m_dr[15:11], m_pc};
      default: ;
    endcase
    case (f1)
      3'd1: ac_n = m_ac + m_dr;
      3'd2: ac_n = 16'd0;
      3'd3: ac_n = m_ac + 16'd1;
      3'd4: ac_n = m_dr;
      3'd5: ar_n = m_dr[10:0];
      3'd6: ar_n = m_pc;
      default: ;
    endcase
    @(posedge clk_i);
    m_ac = ac_n; m_dr = dr_n; m_ar = ar_n; m_pc = pc_n;
    #1;
    check_state(tag);
  endtask

  // AC via DR, PC via AR
  task automatic peek(input string tag);
    step(3'd0, 3'd5, 3'd0, 16'h0, {tag, " AC readback"});
    step(3'd6, 3'd0, 3'd0, 16'h0, {tag, " PC readback"});
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] p, input logic [15:0] d);
    step(3'd0, 3'd4, 3'd0, a, "R8 load DR");
    step(3'd4, 3'd0, 3'd0, 16'h0, "R3 DR to AC");
    step(3'd0, 3'd4, 3'd0, p, "R8 load DR");
    step(3'd5, 3'd0, 3'd0, 16'h0, "R6 DR to AR");
    step(3'd0, 3'd0, 3'd6, 16'h0, "R6 AR to PC");
    step(3'd5, 3'd4, 3'd0, d, "R9 AR from old DR");
  endtask

  bit done = 1'b0;
  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #12;
    // R1 reset state
    chk("R1 reset AR", 32'(mem_addr_o), 32'd0);
    chk("R1 reset DR", 32'(mem_wdata_o), 32'd0);
    chk("R1 reset zero", 32'(zero_o), 32'd1);
    chk("R1 reset sign", 32'(sign_o), 32'd0);
    chk("R1 reset we", 32'(mem_we_o), 32'd0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2 all-zero fields change nothing
    load(16'h8001, 16'h0123, 16'hF456);
    step(3'd0, 3'd0, 3'd0, 16'hFFFF, "R2 nop");
    peek("R2 nop");

    // R10 clear plus subtract: clear wins
    load(16'h1234, 16'h0055, 16'h0011);
    step(3'd2, 3'd1, 3'd0, 16'h0, "R10 clear over sub");
    chk("R10 AC zero", 32'(zero_o), 32'd1);
    // R10 F2 over F3
    load(16'h00F0, 16'h0001, 16'h0F0F);
    step(3'd0, 3'd2, 3'd2, 16'h0, "R10 or over com");
    peek("R10");

    // R9 AR takes old DR while DR increments
    load(16'h0000, 16'h0200, 16'h07FF);
    step(3'd5, 3'd6, 3'd5, 16'h0, "R9 concurrent");
    chk("R9 AR old DR", 32'(mem_addr_o), 32'h7FF);
    chk("R9 DR incremented", 32'(mem_wdata_o), 32'h0800);

    // R12 partial DR load keeps upper bits
    load(16'h0000, 16'h0345, 16'hA800);
    step(3'd0, 3'd7, 3'd0, 16'h0, "R12 PC to DR");
    chk("R12 DR value", 32'(mem_wdata_o), 32'hA800 | 32'h0345);

    // R5 logical right shift, R3 wrap
    load(16'h8000, 16'h0000, 16'h0001);
    step(3'd0, 3'd0, 3'd4, 16'h0, "R5 shr");
    chk("R5 shr sign clear", 32'(sign_o), 32'd0);
    load(16'hFFFF, 16'h0000, 16'h0001);
    step(3'd1, 3'd0, 3'd0, 16'h0, "R3 add wrap");
    chk("R3 add wrap zero", 32'(zero_o), 32'd1);
    step(3'd7, 3'd0, 3'd0, 16'h0, "R7 write");

    // sweep of all field combinations (R3 R4 R5 R6 R10)
    for (int f1 = 0; f1 < 8; f1++)
      for (int f2 = 0; f2 < 8; f2++)
        for (int f3 = 0; f3 < 8; f3++) begin
          load(rnd(), rnd(), rnd());
          step(3'(f1), 3'(f2), 3'(f3), rnd(), "R3/R4/R5 sweep");
          peek("R10 sweep");
        end

    // R1 asynchronous reset mid-cycle
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async AR", 32'(mem_addr_o), 32'd0);
    chk("R1 async DR", 32'(mem_wdata_o), 32'd0);
    chk("R1 async zero", 32'(zero_o), 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule